// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

This block turns a byte into a serial stream. A level-sensitive load input forces all eight stages straight from a parallel word. The force acts through a direct set and a direct clear on each stage, so it takes effect without any clock edge. When the load is released, every rising edge of the shift clock does two things: it moves the contents one stage toward the far end, and it fills the near end from a serial input.

Only the three stages at the far end are visible at the ports. The shifted-out bit appears on the last of these. A typical use is to cascade several instances: the last tap of one instance feeds the serial input of the next, which builds a longer parallel-in, serial-out chain. There is no reset input. Taking the load high is the only way to put the contents into a known state, and without load or clock activity the contents stay as they are.

Top module: `plsr_shift8`

## Requirements
- R1: While `load_i` is low, each rising edge of `clk_i` moves stage i into stage i+1 for i = 0..6. On the same edge, stage 0 takes `ser_i`.
- R2: While `load_i` is high, stage i holds `par_i[i]` with no clock edge needed. The value is visible on the taps within the same time step.
- R3: While `load_i` stays high, rising edges of `clk_i` and changes on `ser_i` leave the contents unchanged.
- R4: `tap_o[0]`, `tap_o[1]` and `tap_o[2]` show stages 5, 6 and 7 respectively. Stages 0 to 4 reach no port directly.
- R5: A falling edge of `clk_i` leaves `tap_o` unchanged.
- R6: When `load_i` falls, the loaded word stays in place until the next rising clock edge. That edge performs exactly one shift.
- R7: Starting from a load, the serial bit taken at the first rising edge shows on `tap_o[0]` after edge 6, on `tap_o[1]` after edge 7 and on `tap_o[2]` after edge 8.
- R8: While `load_i` is high, a change on any `par_i` bit reaches its stage at once. A bit is set when load and the input bit are both high, and cleared when load is high and the input bit is low.
- R9: With `load_i` low and `clk_i` idle, the contents are held indefinitely and changes on `par_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock, rising-edge active |
| load_i | input | 1 | Parallel force, active high, level-sensitive, overrides the clock |
| ser_i | input | 1 | Serial bit captured into stage 0 |
| par_i | input | 8 | Parallel word, bit i forces stage i |
| tap_o | output | 3 | Stages 5..7, bit 0 = stage 5 |

## Verification
The bench builds the block with its defaults: eight stages and three taps. With these values a single serial bit takes six to eight edges to travel from the serial input to each tap, so one short stream covers the whole R7 window. A load of a word with only stage 4 set shows that the first hidden stage feeds the lowest tap after one edge. With only three of eight stages observable, the bench gets at the hidden stages by shifting them out through the taps. It then compares every edge against a byte-wide reference model.

// File: rtl/plsr_pkg.sv
`timescale 1ns/1ps
package plsr_pkg;
  parameter int unsigned DEF_STAGES = 8;
  parameter int unsigned DEF_TAPS   = 3;

  // Direct force pair applied to one stage.
  typedef struct packed {
    logic set;
    logic clr;
  } force_t;
endpackage

// File: rtl/plsr_force_dec.sv
`timescale 1ns/1ps
module plsr_force_dec
  import plsr_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_STAGES
) (
  input  logic                   load_i,
  input  logic [WIDTH-1:0]       par_i,
  output force_t [WIDTH-1:0]     frc_o
);
  // Set and clear come from complementary copies of the same bit.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign frc_o[b].set = load_i &  par_i[b];
    assign frc_o[b].clr = load_i & ~par_i[b];
  end
endmodule

// File: rtl/plsr_stage.sv
`timescale 1ns/1ps
module plsr_stage (
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end

  // R2
  set_wins_chk: assert property (@(posedge clk_i) set_i |-> q_o);
  // R2
  clr_wins_chk: assert property (@(posedge clk_i) clr_i |-> !q_o);
endmodule

// File: rtl/plsr_chain.sv
`timescale 1ns/1ps
module plsr_chain
  import plsr_pkg::*;
#(
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic              clk_i,
  input  logic              load_i,
  input  logic              ser_i,
  input  logic [STAGES-1:0] par_i,
  output logic [STAGES-1:0] stage_o
);
  force_t [STAGES-1:0] frc_w;
  logic   [STAGES-1:0] din_w;

  plsr_force_dec #(.WIDTH(STAGES)) u_dec (
    .load_i (load_i),
    .par_i  (par_i),
    .frc_o  (frc_w)
  );

  assign din_w = {stage_o[STAGES-2:0], ser_i};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    plsr_stage u_stage (
      .clk_i (clk_i),
      .set_i (frc_w[s].set),
      .clr_i (frc_w[s].clr),
      .d_i   (din_w[s]),
      .q_o   (stage_o[s])
    );
  end

  // Marks that a shift edge has happened since the last load pulse.
  logic quiet_q;
  always_ff @(posedge clk_i or posedge load_i) begin
    if (load_i) quiet_q <= 1'b0;
    else        quiet_q <= 1'b1;
  end

  // R1
  shift_chk: assert property (@(posedge clk_i) disable iff (load_i)
    quiet_q |-> (stage_o == {$past(stage_o[STAGES-2:0]), $past(ser_i)}));

  // R3
  clk_ignored_chk: assert property (@(posedge clk_i) disable iff (!load_i)
    ($past(load_i) && $stable(par_i)) |-> $stable(stage_o));
endmodule

// File: rtl/plsr_taps.sv
`timescale 1ns/1ps
module plsr_taps #(
  parameter int unsigned TAPS = plsr_pkg::DEF_TAPS
) (
  input  logic [TAPS-1:0] hi_stages_i,
  output logic [TAPS-1:0] tap_o
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_o[t] = hi_stages_i[t];
  end
endmodule

// File: rtl/plsr_shift8.sv
`timescale 1ns/1ps
module plsr_shift8
  import plsr_pkg::*;
#(
  parameter int unsigned STAGES = DEF_STAGES,
  parameter int unsigned TAPS   = DEF_TAPS
) (
  input  logic              clk_i,
  input  logic              load_i,
  input  logic              ser_i,
  input  logic [STAGES-1:0] par_i,
  output logic [TAPS-1:0]   tap_o
);
  localparam int unsigned FIRST_TAP = STAGES - TAPS;

  logic [STAGES-1:0] stage_w;

  plsr_chain #(.STAGES(STAGES)) u_chain (
    .clk_i   (clk_i),
    .load_i  (load_i),
    .ser_i   (ser_i),
    .par_i   (par_i),
    .stage_o (stage_w)
  );

  plsr_taps #(.TAPS(TAPS)) u_taps (
    .hi_stages_i (stage_w[STAGES-1 -: TAPS]),
    .tap_o       (tap_o)
  );

  logic quiet_q;
  always_ff @(posedge clk_i or posedge load_i) begin
    if (load_i) quiet_q <= 1'b0;
    else        quiet_q <= 1'b1;
  end

  // R4
  tap_order_chk: assert property (@(posedge clk_i) disable iff (load_i)
    quiet_q |-> (tap_o == $past(stage_w[FIRST_TAP-1 +: TAPS])));
endmodule

// File: tb/tb_plsr_shift8.sv
`timescale 1ns/100ps
module tb_plsr_shift8;
  logic       clk = 1'b0;
  logic       clk_en = 1'b0;
  logic       load = 1'b0;
  logic       ser = 1'b0;
  logic [7:0] par = 8'h00;
  logic [2:0] tap;

  int         checks = 0;
  int         fails = 0;
  logic [7:0] model = 8'h00;
  logic [2:0] exp_q[$];

  always #2.5 if (clk_en) clk = ~clk;

  plsr_shift8 dut (
    .clk_i  (clk),
    .load_i (load),
    .ser_i  (ser),
    .par_i  (par),
    .tap_o  (tap)
  );

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: taps actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Scoreboard monitor: compares each queued expectation after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) check(tap, exp_q.pop_front(), "R1 shift scoreboard");
    end
  end

  // Called just after a falling edge, before the next rising edge.
  task automatic shift_bit(input logic b);
    ser = b;
    model = {model[6:0], b};
    exp_q.push_back(model[7:5]);
    @(posedge clk);
    @(negedge clk);
    #0.5;
    check(tap, model[7:5], "R5 falling edge");
  endtask

  task automatic load_and_release(input logic [7:0] v);
    load = 1'b1;
    par = v;
    #0.5;
    model = v;
    check(tap, v[7:5], "R2 load");
    @(negedge clk);
    #0.5;
    load = 1'b0;
    #1;
    check(tap, v[7:5], "R6 release hold");
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #3;
    // R2: first force without a clock
    load = 1'b1;
    par = 8'hA5;
    #1;
    model = 8'hA5;
    check(tap, 3'b101, "R2 load no clock");
    // R8: change while load held
    par = 8'h5A;
    #1;
    model = 8'h5A;
    check(tap, 3'b010, "R8 live update");
    clk_en = 1'b1;
    // R3: clock and serial ignored during load
    for (int k = 0; k < 3; k++) begin
      ser = ~ser;
      @(posedge clk);
      #1;
      check(tap, model[7:5], "R3 clock ignored");
    end
    @(negedge clk);
    #0.5;
    load = 1'b0;
    #1;
    check(tap, 3'b010, "R6 release hold");
    shift_bit(1'b1);
    // random streams
    for (int s = 0; s < 4; s++) begin
      load_and_release(8'($urandom));
      for (int k = 0; k < 20; k++) shift_bit(1'($urandom));
    end
    // R4: hidden stage 4 enters tap 0
    load_and_release(8'h10);
    check(tap, 3'b000, "R4 low stages hidden");
    shift_bit(1'b0);
    check(tap, 3'b001, "R4 stage4 to tap0");
    load_and_release(8'hE0);
    check(tap, 3'b111, "R4 top stages");
    // R7: first serial bit travel
    load_and_release(8'h00);
    shift_bit(1'b1);
    for (int e = 2; e <= 8; e++) begin
      shift_bit(1'b0);
      if (e == 6) check(tap, 3'b001, "R7 edge6");
      if (e == 7) check(tap, 3'b010, "R7 edge7");
      if (e == 8) check(tap, 3'b100, "R7 edge8");
    end
    // R9: static hold with idle clock
    load_and_release(8'hC3);
    clk_en = 1'b0;
    #200;
    check(tap, 3'b110, "R9 static hold");
    par = 8'h3C;
    #1;
    check(tap, 3'b110, "R9 par ignored");
    clk_en = 1'b1;
    shift_bit(1'b1);
    shift_bit(1'b0);
    @(posedge clk);
    #2;
    finish_run();
  end
endmodule